// File: doc/BRIEF.md
# Windowed Watchdog with Two-Key Refresh

This block is a supervision timer built around a 14-bit down-counter. Software talks to it over a small register bus with separate write and read strobes. The counter is paced by a count tick. That tick is derived from a low-speed clock enable: the enable pulses are divided by a power of two chosen in a 4-bit select field. The counter stays idle after reset. It starts running the first time software completes a refresh.

A refresh is a two-write key sequence sent to a dedicated key register. The first key is 00h and it arms the sequence. The second key is FFh and it fires the sequence. Repeated 00h writes, reads, and accesses to other registers do not disarm a pending sequence. Any other value written to the key register does disarm it. Once the counter is running, a firing write counts as in-window only when the live count is at or below the programmed window start and strictly above the programmed window end. An in-window fire reloads the counter to 3FFFh after a synchroniser delay. An out-of-window fire does not reload the counter; instead it raises the error flag and a reset request.

When a count tick finds the counter at zero with no reload due, the block sets its sticky error flag and pulses a one-cycle reset request. The counter then wraps to 3FFFh. The live count, a running bit and the error flag can all be read from the status register.

Top module: `winwdog_top`

## Requirements
- R1: After reset the status register reads 0x3FFF (count 3FFFh, running bit 0, error 0), err_flag and rst_req are low, and the count does not change on count ticks until the first accepted refresh.
- R2: Once running, the count falls by one on every count tick, and a count tick occurs once every 2^sel low-speed enable pulses, where sel is bits [3:0] of the config register.
- R3: A write of 00h to the key register arms the refresh, and the next write of FFh to the key register fires it. Further 00h writes, reads of any register, and writes to other registers in between leave the refresh armed.
- R4: An FFh key write without a pending arm does nothing. Any key value other than 00h or FFh disarms a pending arm, so 23h→FFh, 00h→54h and 00h→AAh→FFh refresh nothing.
- R5: Take the edge that captures an accepted FFh write. The counter keeps counting for the next two edges. It is reloaded to 3FFFh by the first count tick that comes three or more edges after that edge, and from then on the running bit reads 1.
- R6: While running, a fire is accepted only when the count is at or below the window start and strictly above the window end. Otherwise the fire causes no reload, sets the error flag, and rst_req is high for exactly one cycle. A fire while idle is always accepted.
- R7: The 00h key may be written while the count is outside the window. A later FFh that lands inside the window is accepted with no error.
- R8: A count tick at count 0 with no reload due pulses rst_req for one cycle, sets the error flag, and wraps the count to 3FFFh.
- R9: The error flag (err_flag and status bit 15) is sticky. A status write with bit 15 set clears it, unless an error event occurs in the same cycle, in which case the flag stays set.
- R10: Register addresses are: 0 config (sel in bits [3:0]); 1 window start (bits [13:0], reset 3FFFh); 2 window end (bits [13:0], reset 0); 3 key (data bits [7:0], reads 0); 4 status ({err, running, count[13:0]}). bus_rdata is updated on the edge that samples bus_rd and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ls_tick | input | 1 | Low-speed clock enable, one pulse per low-speed cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| err_flag | output | 1 | Sticky error flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Three results come out of registers on the edge that consumes their cause: bus_rdata on the edge that samples bus_rd, and err_flag and rst_req on the edge that captures a fire or an underflow tick. The reload comes out of the counter register no earlier than three edges after the FFh write edge. The behavioural model in the bench applies these same edge counts. Its outputs are compared with the design at every falling edge, so each result is checked in the cycle it is due. Directed checks hold bus_rd high across the reload and sample each falling edge. This shows the two extra decrements that R5 allows before the counter jumps to 3FFFh.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;
  typedef enum logic [2:0] {
    A_CFG    = 3'd0,
    A_WSTART = 3'd1,
    A_WEND   = 3'd2,
    A_KEY    = 3'd3,
    A_STAT   = 3'd4
  } reg_addr_e;

  localparam logic [7:0] KEY_ARM  = 8'h00;
  localparam logic [7:0] KEY_FIRE = 8'hFF;
endpackage

// File: rtl/winwdog_presc.sv
module winwdog_presc #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ls_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             cnt_tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pc_q;
  logic [PRE_W:0]   lim_full;
  logic [PRE_W-1:0] lim;
  logic             unused_lim_top;

  always_comb begin
    lim_full = ({{PRE_W{1'b0}}, 1'b1} << sel) - 1'b1;
    lim      = lim_full[PRE_W-1:0];
  end
  assign unused_lim_top = lim_full[PRE_W];

  assign cnt_tick = ls_tick && (pc_q >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (ls_tick) begin
      if (pc_q >= lim) pc_q <= '0;
      else             pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/winwdog_key.sv
module winwdog_key #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [7:0]       key_data,
  input  logic [CNT_W-1:0] cnt,
  input  logic             running,
  input  logic [CNT_W-1:0] wstart,
  input  logic [CNT_W-1:0] wend,
  output logic             refresh_ok,
  output logic             win_viol
);
  import winwdog_pkg::*;

  logic armed_q;
  logic fire;
  logic in_win;

  assign fire       = key_wr && (key_data == KEY_FIRE) && armed_q;
  assign in_win     = (cnt <= wstart) && (cnt > wend);
  assign win_viol   = fire && running && !in_win;
  assign refresh_ok = fire && !win_viol;

  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (key_wr) armed_q <= (key_data == KEY_ARM);
  end
endmodule

// File: rtl/winwdog_cnt.sv
module winwdog_cnt #(
  parameter int CNT_W  = 14,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             refresh,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             reload,
  output logic             uflow
);
  logic [SYNC_N:0] pend_q;

  assign reload = tick && pend_q[SYNC_N];
  assign uflow  = tick && running && !reload && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) pend_q[0] <= 1'b0;
    else     pend_q[0] <= refresh || (pend_q[0] && !reload);
  end

  for (genvar i = 1; i <= SYNC_N; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst || reload) pend_q[i] <= 1'b0;
      else               pend_q[i] <= pend_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '1;
      running <= 1'b0;
    end else if (reload) begin
      cnt     <= '1;
      running <= 1'b1;
    end else if (tick && running) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/winwdog_regs.sv
module winwdog_regs #(
  parameter int CNT_W  = 14,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  logic              err_set,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  wstart,
  output logic [CNT_W-1:0]  wend,
  output logic              key_wr,
  output logic [7:0]        key_data,
  output logic              err_flag,
  output logic [DATA_W-1:0] rdata
);
  import winwdog_pkg::*;

  localparam int PAD_W = DATA_W - CNT_W - 2;

  logic unused_wbit;
  logic clr_req;

  assign key_wr      = bus_wr && (bus_addr == A_KEY);
  assign key_data    = bus_wdata[7:0];
  assign clr_req     = bus_wr && (bus_addr == A_STAT) && bus_wdata[DATA_W-1];
  assign unused_wbit = bus_wdata[DATA_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      wstart <= '1;
      wend   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CFG:    sel    <= bus_wdata[SEL_W-1:0];
        A_WSTART: wstart <= bus_wdata[CNT_W-1:0];
        A_WEND:   wend   <= bus_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
    else if (clr_req) err_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CFG:    rdata <= {{(DATA_W-SEL_W){1'b0}}, sel};
        A_WSTART: rdata <= {{(DATA_W-CNT_W){1'b0}}, wstart};
        A_WEND:   rdata <= {{(DATA_W-CNT_W){1'b0}}, wend};
        A_STAT:   rdata <= {err_flag, running, {PAD_W{1'b0}}, cnt};
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/winwdog_top.sv
module winwdog_top #(
  parameter int CNT_W  = 14,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ls_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              err_flag,
  output logic              rst_req
);
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] wstart, wend, cnt_q;
  logic             key_wr, cnt_tick, running, reload, uflow;
  logic             refresh_ok, win_viol, err_set;
  logic [7:0]       key_data;

  assign err_set = win_viol || uflow;

  winwdog_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q),
    .running(running), .err_set(err_set), .sel(sel), .wstart(wstart),
    .wend(wend), .key_wr(key_wr), .key_data(key_data),
    .err_flag(err_flag), .rdata(bus_rdata)
  );

  winwdog_presc #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst(rst), .ls_tick(ls_tick), .sel(sel), .cnt_tick(cnt_tick)
  );

  winwdog_key #(.CNT_W(CNT_W)) u_key (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(key_data),
    .cnt(cnt_q), .running(running), .wstart(wstart), .wend(wend),
    .refresh_ok(refresh_ok), .win_viol(win_viol)
  );

  winwdog_cnt #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_tick), .refresh(refresh_ok),
    .cnt(cnt_q), .running(running), .reload(reload), .uflow(uflow)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= err_set;
  end
endmodule

// File: rtl/winwdog_chk.sv
module winwdog_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             reload,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic             win_viol,
  input logic             err_set,
  input logic             clr_req,
  input logic             err_flag,
  input logic             rst_req
);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!running && !reload) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    reload |=> (running && cnt == '1));

  p_viol_req_r6: assert property (@(posedge clk) disable iff (rst)
    win_viol |=> (rst_req && err_flag));

  p_uflow_r8: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !reload && cnt == '0) |=> (rst_req && cnt == '1));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !err_set) |=> !err_flag);

  p_req_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> err_flag);
endmodule

bind winwdog_top winwdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(cnt_tick), .reload(reload),
  .running(running), .cnt(cnt_q), .win_viol(win_viol), .err_set(err_set),
  .clr_req(bus_wr && bus_addr == 3'd4 && bus_wdata[DATA_W-1]),
  .err_flag(err_flag), .rst_req(rst_req)
);

// File: tb/winwdog_top_tb_top.sv
module winwdog_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ls_tick = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        err_flag, rst_req;

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_pc, m_cnt, m_run, m_armed, m_age, m_err, m_req, m_rdata, m_sel, m_ws, m_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  winwdog_top dut_i (
    .clk(clk), .rst(rst), .ls_tick(ls_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_flag(err_flag), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_cnt = 16'h3FFF; m_run = 0; m_armed = 0; m_age = -1;
      m_err = 0; m_req = 0; m_rdata = 0; m_sel = 0; m_ws = 16'h3FFF; m_we = 0;
    end else begin
      int lim, tk, fire, inwin, viol, rl, uf;
      lim = (1 << m_sel) - 1;
      tk = 0;
      if (ls_tick) begin
        if (m_pc >= lim) begin tk = 1; m_pc = 0; end
        else m_pc++;
      end
      fire  = (bus_wr && bus_addr == 3 && bus_wdata[7:0] == 8'hFF && m_armed != 0) ? 1 : 0;
      inwin = (m_cnt <= m_ws && m_cnt > m_we) ? 1 : 0;
      viol  = (fire != 0 && m_run != 0 && inwin == 0) ? 1 : 0;
      if (bus_wr && bus_addr == 3) m_armed = (bus_wdata[7:0] == 8'h00) ? 1 : 0;
      if (m_age >= 0) m_age++;
      rl = (tk != 0 && m_age >= 3) ? 1 : 0;
      uf = (tk != 0 && m_run != 0 && rl == 0 && m_cnt == 0) ? 1 : 0;
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rdata = m_sel;
          3'd1: m_rdata = m_ws;
          3'd2: m_rdata = m_we;
          3'd4: m_rdata = m_err * 32768 + m_run * 16384 + m_cnt;
          default: m_rdata = 0;
        endcase
      end
      if (rl != 0) begin m_cnt = 16'h3FFF; m_run = 1; m_age = -1; end
      else if (tk != 0 && m_run != 0) m_cnt = (m_cnt == 0) ? 16'h3FFF : m_cnt - 1;
      if (fire != 0 && viol == 0 && m_age < 0) m_age = 0;
      if (viol != 0 || uf != 0) m_err = 1;
      else if (bus_wr && bus_addr == 4 && bus_wdata[15]) m_err = 0;
      m_req = (viol != 0 || uf != 0) ? 1 : 0;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_sel = bus_wdata[3:0];
          3'd1: m_ws  = bus_wdata[13:0];
          3'd2: m_we  = bus_wdata[13:0];
          default: ;
        endcase
      end
    end
  end

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 R8 rst_req vs model", rst_req, m_req);
      chk("R9 err_flag vs model", err_flag, m_err);
      chk("R10 bus_rdata vs model", bus_rdata, m_rdata);
      if (rst_req) n_pulse++;
    end
  end

  task automatic wr(input [2:0] a, input [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input [2:0] a, output int v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, a, b, s1, s3, s4, p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 err_flag after reset", err_flag, 0);
    chk("R1 rst_req after reset", rst_req, 0);
    rd(3'd4, v); chk("R1 status after reset", v, 16'h3FFF);
    repeat (30) @(negedge clk);
    rd(3'd4, v); chk("R1 idle count holds", v, 16'h3FFF);

    // invalid sequences
    wr(3'd3, 16'h00FF);
    wr(3'd3, 16'h0023); wr(3'd3, 16'h00FF);
    wr(3'd3, 16'h0000); wr(3'd3, 16'h00AA); wr(3'd3, 16'h00FF);
    wr(3'd3, 16'h0000); wr(3'd3, 16'h0054); wr(3'd3, 16'h00FF);
    repeat (10) @(negedge clk);
    rd(3'd4, v); chk("R4 no refresh from invalid keys", v, 16'h3FFF);

    // valid sequence with repeats, reads and other accesses between keys
    wr(3'd3, 16'h0000); wr(3'd3, 16'h0000);
    rd(3'd3, v); chk("R10 key register reads zero", v, 0);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); chk("R10 config readback", v, 0);
    wr(3'd3, 16'h00FF);
    repeat (10) @(negedge clk);
    rd(3'd4, v);
    chk("R3 refresh started counter", (v >> 14) & 1, 1);
    chk("R3 count moved below 3FFF", ((v & 16'h3FFF) < 16'h3FFF && (v & 16'h3FFF) > 16'h3FE0) ? 1 : 0, 1);

    // reload latency
    wr(3'd3, 16'h0000);
    wr(3'd3, 16'h00FF);
    bus_rd = 1'b1; bus_addr = 3'd4;
    @(negedge clk); s1 = bus_rdata & 16'h3FFF;
    @(negedge clk);
    @(negedge clk); s3 = bus_rdata & 16'h3FFF;
    @(negedge clk); s4 = bus_rdata & 16'h3FFF;
    bus_rd = 1'b0;
    chk("R5 two more decrements before reload", s3, s1 - 2);
    chk("R5 reload to 3FFF", s4, 16'h3FFF);

    // prescaler select
    wr(3'd0, 16'h0002);
    rd(3'd4, a);
    repeat (38) @(negedge clk);
    rd(3'd4, b);
    chk("R2 ten ticks in 40 cycles at sel 2", (a & 16'h3FFF) - (b & 16'h3FFF), 10);

    // out-of-window fire (count above start)
    wr(3'd0, 16'h0004);
    wr(3'd1, 16'h3000);
    p0 = n_pulse;
    wr(3'd3, 16'h0000); wr(3'd3, 16'h00FF);
    @(negedge clk);
    chk("R6 err set on early fire", err_flag, 1);
    chk("R6 one reset request pulse", n_pulse - p0, 1);

    wr(3'd4, 16'h8000);
    chk("R9 err cleared by write", err_flag, 0);

    // arm outside window, fire inside
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h3FFF);
    rd(3'd1, v); chk("R10 window start readback", v, 16'h3FFF);
    p0 = n_pulse;
    wr(3'd3, 16'h00FF);
    repeat (4) @(negedge clk);
    chk("R7 no error on in-window fire", err_flag, 0);
    chk("R7 no reset request", n_pulse - p0, 0);

    // fire with count at or below window end
    wr(3'd2, 16'h3FFF);
    wr(3'd3, 16'h0000); wr(3'd3, 16'h00FF);
    @(negedge clk);
    chk("R6 err set on late fire", err_flag, 1);
    wr(3'd4, 16'h8000);
    wr(3'd2, 16'h0000);

    // underflow
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0000); wr(3'd3, 16'h00FF);
    p0 = n_pulse;
    chk("R9 err clear before underflow", err_flag, 0);
    repeat (16400) @(negedge clk);
    chk("R8 one underflow pulse", n_pulse - p0, 1);
    chk("R8 err set by underflow", err_flag, 1);
    rd(3'd4, v);
    chk("R8 count wrapped near top", ((v & 16'h3FFF) > 16'h3FC0) ? 1 : 0, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule